// File: doc/BRIEF.md
# Zero-Page Auto-Modify Index Unit

This unit resolves the operand address of an extended memory-to-memory instruction. The caller passes an 8-bit zero-page location that holds a 16-bit pointer. The unit reads the pointer through a byte-wide synchronous memory port and returns it as the effective address. It may then write an updated pointer back to the same location.

Whether the pointer changes, and in which direction, depends only on where the index location sits in zero page. It never depends on the instruction encoding. The lowest two locations are forbidden as an index. The next range post-increments the pointer and the range after that post-decrements it. The upper half of zero page leaves the pointer unchanged.

The step size is an input, so the same unit serves byte operands and 16-bit operands. A single-cycle `start_i` begins a resolution, and a single-cycle `done_o` ends it.

Top module: `zp_index_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o`, `err_o`, `mem_rd_o` and `mem_wr_o` are all low.
- R2: An index location of 0x00 or 0x01 raises `err_o` together with `done_o` for one cycle. This happens right after the edge that samples `start_i`. No memory read or write is issued.
- R3: For an index location in 0x02 to 0x3F, the stored pointer is written back increased by the step.
- R4: For an index location in 0x40 to 0x7F, the stored pointer is written back decreased by the step.
- R5: For an index location in 0x80 to 0xFF, the stored pointer is read but never written.
- R6: When `done_o` is high without `err_o`, `ea_o` equals the pointer value as it was before any modification.
- R7: The pointer is little-endian. The low byte is at the index location and the high byte is at the index location plus one, wrapping within zero page (0xFF pairs with 0x00). Writes go low byte first, then high byte at the next address.
- R8: The pointer update wraps modulo 65536.
- R9: `step_two_i` = 0 selects a step of 1, and `step_two_i` = 1 selects a step of 2.
- R10: Edges are counted with the edge that samples `start_i` as edge 0. `done_o` is high for exactly one cycle after edge 3 for an unmodified pointer and after edge 5 for a modified one. `mem_wr_o` is high after edges 3 and 4 only when the pointer is modified, and never in the same cycle as `mem_rd_o`.
- R11: `start_i` asserted while a resolution is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a resolution (sampled when idle) |
| idx_loc_i | input | 8 | Zero-page index location |
| step_two_i | input | 1 | 0: step 1, 1: step 2 |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | 8 | Zero-page byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the read request is sampled |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Forbidden index, valid with `done_o` |
| ea_o | output | 16 | Effective address (pointer before update) |

## Verification
The assertions check on every cycle the following properties:
- Reads and writes are mutually exclusive.
- An error never appears without completion.
- Completion lasts one cycle.
- The high-byte write immediately follows the low-byte write at the next address.
- No write ever lands on the two forbidden locations.

Only the bench scenarios can show the range-dependent values: the incremented or decremented pointer left in memory, the effective address, the wrap of the pointer and of the zero-page pair at 0xFF, the exact completion latency per range, and that a start pulse during a busy resolution leaves the result untouched.

// File: rtl/zpidx_pkg.sv
package zpidx_pkg;
  typedef enum logic [1:0] {MODE_BAD, MODE_INC, MODE_DEC, MODE_FIX} mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RD_LO, ST_RD_HI, ST_CAP, ST_WR_LO, ST_WR_HI} state_e;
endpackage

// File: rtl/zpidx_classify.sv
module zpidx_classify
  import zpidx_pkg::*;
#(
  parameter int AW       = 8,
  parameter int INC_BASE = 2,
  parameter int DEC_BASE = 64,
  parameter int FIX_BASE = 128
) (
  input  logic [AW-1:0] loc_i,
  output mode_e         mode_o
);
  always_comb begin
    if (int'(loc_i) < INC_BASE)      mode_o = MODE_BAD;
    else if (int'(loc_i) < DEC_BASE) mode_o = MODE_INC;
    else if (int'(loc_i) < FIX_BASE) mode_o = MODE_DEC;
    else                             mode_o = MODE_FIX;
  end
endmodule

// File: rtl/zpidx_update.sv
module zpidx_update
  import zpidx_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [PW-1:0] ptr_i,
  input  mode_e         mode_i,
  input  logic          step_two_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW-1:0] step;
  assign step = step_two_i ? PW'(2) : PW'(1);

  always_comb begin
    unique case (mode_i)
      MODE_INC: ptr_o = ptr_i + step;
      MODE_DEC: ptr_o = ptr_i - step;
      default:  ptr_o = ptr_i;
    endcase
  end
endmodule

// File: rtl/zpidx_fsm.sv
module zpidx_fsm
  import zpidx_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] idx_loc_i,
  input  logic          step_two_i,
  input  mode_e         mode_in_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [PW-1:0] next_ptr_i,
  output mode_e         mode_q_o,
  output logic          step_q_o,
  output logic [DW-1:0] lo_q_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic [PW-1:0] ea_o
);
  state_e        state;
  logic [AW-1:0] loc_q;
  logic [DW-1:0] hi_new_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      loc_q       <= '0;
      step_q_o    <= 1'b0;
      mode_q_o    <= MODE_FIX;
      lo_q_o      <= '0;
      hi_new_q    <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      ea_o        <= '0;
    end else begin
      mem_rd_o <= 1'b0;
      mem_wr_o <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          loc_q    <= idx_loc_i;
          step_q_o <= step_two_i;
          mode_q_o <= mode_in_i;
          if (mode_in_i == MODE_BAD) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            mem_rd_o   <= 1'b1;
            mem_addr_o <= idx_loc_i;
            state      <= ST_RD_LO;
          end
        end
        ST_RD_LO: begin
          mem_rd_o   <= 1'b1;
          mem_addr_o <= loc_q + AW'(1);
          state      <= ST_RD_HI;
        end
        ST_RD_HI: begin
          lo_q_o <= mem_rdata_i;
          state  <= ST_CAP;
        end
        ST_CAP: begin
          ea_o <= {mem_rdata_i, lo_q_o};
          if (mode_q_o == MODE_FIX) begin
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            mem_wr_o    <= 1'b1;
            mem_addr_o  <= loc_q;
            mem_wdata_o <= next_ptr_i[DW-1:0];
            hi_new_q    <= next_ptr_i[PW-1:DW];
            state       <= ST_WR_LO;
          end
        end
        ST_WR_LO: begin
          mem_wr_o    <= 1'b1;
          mem_addr_o  <= loc_q + AW'(1);
          mem_wdata_o <= hi_new_q;
          state       <= ST_WR_HI;
        end
        ST_WR_HI: begin
          done_o <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/zp_index_unit.sv
module zp_index_unit
  import zpidx_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int INC_BASE = 2,
  parameter int DEC_BASE = 64,
  parameter int FIX_BASE = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [7:0]    idx_loc_i,
  input  logic          step_two_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [7:0]    mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic [15:0]   ea_o
);
  localparam int PW = 2 * DW;

  mode_e         mode_in, mode_q;
  logic          step_q;
  logic [DW-1:0] lo_q;
  logic [PW-1:0] next_ptr;

  zpidx_classify #(.AW(AW), .INC_BASE(INC_BASE), .DEC_BASE(DEC_BASE), .FIX_BASE(FIX_BASE))
    u_cls (.loc_i(idx_loc_i), .mode_o(mode_in));

  zpidx_update #(.PW(PW))
    u_upd (.ptr_i({mem_rdata_i, lo_q}), .mode_i(mode_q), .step_two_i(step_q), .ptr_o(next_ptr));

  zpidx_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .idx_loc_i(idx_loc_i),
    .step_two_i(step_two_i), .mode_in_i(mode_in), .mem_rdata_i(mem_rdata_i),
    .next_ptr_i(next_ptr), .mode_q_o(mode_q), .step_q_o(step_q), .lo_q_o(lo_q),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .done_o(done_o), .err_o(err_o), .ea_o(ea_o)
  );
endmodule

// File: rtl/zpidx_checker.sv
module zpidx_checker (
  input logic       clk,
  input logic       rst,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic [7:0] mem_addr_o,
  input logic       done_o,
  input logic       err_o
);
  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  assert_err_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  assert_no_forbidden_write_R2: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> (mem_addr_o >= 8'd2));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_hi_follows_lo_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_o) |=> (mem_wr_o && mem_addr_o == $past(mem_addr_o) + 8'd1));

  assert_done_after_write_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr_o) |-> done_o);
endmodule

bind zp_index_unit zpidx_checker u_chk (
  .clk(clk), .rst(rst), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .mem_addr_o(mem_addr_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_zp_index_unit.sv
module sim_zp_index_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  idx_loc_i = '0;
  logic        step_two_i = 1'b0;
  logic        mem_rd_o, mem_wr_o, done_o, err_o;
  logic [7:0]  mem_addr_o, mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [15:0] ea_o;
  logic [7:0]  mem [256];
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  zp_index_unit u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .idx_loc_i(idx_loc_i),
    .step_two_i(step_two_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .err_o(err_o), .ea_o(ea_o)
  );

  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural model of one resolution, compared on every clock.
  task automatic run_op(input logic [7:0] loc, input bit two, input int ptr,
                        input string req, input bit poke);
    int step, mode, newp, lat, lo_a, hi_a;
    bit wrote;
    step = two ? 2 : 1;
    lo_a = loc;
    hi_a = (loc + 1) % 256;
    mode = (loc < 2) ? 0 : (loc < 64) ? 1 : (loc < 128) ? 2 : 3;
    newp = (mode == 1) ? (ptr + step) % 65536 :
           (mode == 2) ? (ptr - step + 65536) % 65536 : ptr;
    lat  = (mode == 0) ? 0 : (mode == 3) ? 3 : 5;
    mem[lo_a] = ptr[7:0];
    mem[hi_a] = ptr[15:8];
    @(negedge clk);
    idx_loc_i = loc; step_two_i = two; start_i = 1'b1;
    wrote = 1'b0;
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke && k == 1) begin start_i = 1'b1; idx_loc_i = 8'h00; end
      if (mem_wr_o) wrote = 1'b1;
      chk(done_o == (k == lat), {req, " R10 done timing"}, done_o, k == lat);
      chk(mem_wr_o == (lat == 5 && (k == 3 || k == 4)), {req, " R10 write timing"}, mem_wr_o, 0);
      chk(err_o == (mode == 0 && k == lat), {req, " R2 err"}, err_o, mode == 0);
      if (mode == 0) chk(!mem_rd_o, {req, " R2 no read"}, mem_rd_o, 0);
    end
    start_i = 1'b0;
    if (mode != 0) chk(ea_o == ptr[15:0], {req, " R6 ea"}, ea_o, ptr);
    chk({mem[hi_a], mem[lo_a]} == newp[15:0], {req, " R7 pointer in memory"},
        {mem[hi_a], mem[lo_a]}, newp);
    if (mode == 3 || mode == 0) chk(!wrote, {req, " R5 no write"}, wrote, 0);
    @(negedge clk);
    chk(!done_o, {req, " R11 no extra op"}, done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7);
    repeat (2) @(negedge clk);
    chk(!done_o && !err_o && !mem_rd_o && !mem_wr_o, "R1 reset", done_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done_o && !err_o && !mem_rd_o && !mem_wr_o, "R1 after reset", mem_wr_o, 0);
    run_op(8'h00, 0, 16'h1234, "R2 loc00", 0);
    run_op(8'h01, 1, 16'h5678, "R2 loc01", 0);
    run_op(8'h02, 0, 16'h1000, "R3 R9 inc step1", 0);
    run_op(8'h3F, 1, 16'h20FE, "R3 R9 inc step2 carry", 0);
    run_op(8'h10, 1, 16'hFFFF, "R8 inc wrap", 0);
    run_op(8'h40, 0, 16'h3000, "R4 dec step1", 0);
    run_op(8'h7F, 1, 16'h0001, "R4 R8 dec wrap", 0);
    run_op(8'h55, 1, 16'h0100, "R4 dec borrow", 0);
    run_op(8'h80, 1, 16'hBEEF, "R5 plain", 0);
    run_op(8'hFF, 0, 16'hCAFE, "R5 R7 zp wrap", 0);
    run_op(8'h20, 0, 16'h00FF, "R11 busy start", 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++; n_run++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule